// File: doc/BRIEF.md
# IR Pulse-Width Capture Receiver

This block times the intervals between selected transitions on a single infrared input line and queues one capture word per interval. A programmable prescaler divides the core clock into timing ticks. A width counter runs on those ticks from one qualifying edge to the next. When the next edge arrives, the counter value is packed with the logic level of the interval that just ended and pushed into a small receive queue. A host reads that queue through a simple synchronous register port.

When the line stays quiet until the counter passes its maximum, the block queues an all-ones end-of-reception word and raises a sticky timeout flag. A write into a full queue is dropped and raises a sticky overrun flag. Neither flag has a write-to-clear path. The overrun flag clears only when the queue enable is cycled, and the timeout flag clears only when the receiver enable is cycled. A service-request flag follows a selectable fill watermark. One interrupt line combines every flag whose enable bit is set.

Top module: `irpw_rx_top`

## Requirements
- R1: With divider register (address 1, bits [15:0]) holding D, the width counter advances once every D+1 core clocks while the receiver is enabled.
- R2: The width counter is CNT_W bits wide (default 18). A capture word carries counter bits [CNT_W-1:2] in bits [15:0], zero-extended, so the two lowest bits are dropped. With D=0, an interval of N clocks between qualifying edges captures (N-1)>>2.
- R3: Reading the queue at address 4 pops one word. Bits [15:0] hold the width, bit 16 holds the level of the interval that ended (1 = line high), and bit 17 is 1 for valid data. Reading an empty queue returns all zeros.
- R4: If the counter would pass its maximum while timing, the block queues the word 0x1FFFF (read back as 0x3FFFF), stops timing, and sets the timeout flag (status bit 0).
- R5: Control bits [3:2] select the qualifying edges: 00 none, 01 falling only, 10 rising only, 11 both. The first qualifying edge after enable only starts timing. With 00, nothing is timed or queued.
- R6: The queue holds 8 words. A push into a full queue drops the word and sets the overrun flag (status bit 1).
- R7: Control bit 4 selects the watermark. When it is 1, service request (status bit 2) is high whenever the queue is not empty. When it is 0, service request is high when the queue holds at least 4 words.
- R8: Control bit 1 enables the queue. While it is 0, the queue is emptied and the overrun flag is clear. Cycling this bit is the only way to clear overrun.
- R9: The timeout flag stays set until control bit 0 (receiver enable) is brought low. Enabling the receiver again leaves it clear.
- R10: Status bit 3 (busy) is high while an interval is being timed. With control bit 0 low, the counter and prescaler are held at zero, busy is low, and no word is queued.
- R11: The interrupt-enable register (address 2) has bit 0 for timeout, bit 1 for overrun and bit 2 for service request. The irq output is high exactly when some enabled flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the prescaler reference |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Asynchronous infrared line |
| reg_addr | input | 3 | Register address (0 control, 1 divider, 2 irq enable, 3 status, 4 queue) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Register read strobe; read data appears on the next clock |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
Random trains of three alternating intervals are timed with divider 0, where each captured width and level is exact. Wrong levels, off-by-one counts or a wrong bit slice all show up in this mode. A run with divider 3 on the same kind of train separates correct prescaling from a prescaler that is ignored. Directed trains then apply each edge-select code to the same waveform: falling-only and rising-only must yield one full-period word with opposite levels, and none must yield nothing. Bursts of nine and of four or five intervals exercise overrun, the two watermarks and interrupt masking. A long quiet line exercises the end marker and the enable-cycling clear rules.

// File: rtl/irpw_pkg.sv
package irpw_pkg;

    localparam int WIDTH_FIELD_W = 16;
    localparam int CAP_W         = WIDTH_FIELD_W + 1;

    localparam logic [2:0] ADDR_CTRL  = 3'd0;
    localparam logic [2:0] ADDR_DIV   = 3'd1;
    localparam logic [2:0] ADDR_IRQEN = 3'd2;
    localparam logic [2:0] ADDR_STAT  = 3'd3;
    localparam logic [2:0] ADDR_QUEUE = 3'd4;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic      wm_any;
        edge_sel_e edges;
        logic      q_en;
        logic      rx_en;
    } ctrl_t;

    typedef struct packed {
        logic svc;
        logic ovr;
        logic tmo;
    } flag_vec_t;

    typedef struct packed {
        logic                     level;
        logic [WIDTH_FIELD_W-1:0] width;
    } cap_word_t;

    function automatic logic edge_hit(edge_sel_e sel, logic prev, logic cur);
        return (sel[0] && prev && !cur) || (sel[1] && !prev && cur);
    endfunction

    function automatic cap_word_t end_marker();
        cap_word_t w;
        w.level = 1'b1;
        w.width = '1;
        return w;
    endfunction

endpackage

// File: rtl/irpw_prescaler.sv
module irpw_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    assign tick_o = en && (cnt_q >= div_i);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q >= div_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick_o && en && div_i != '0) |=> (!tick_o || div_i == '0)); // R1

endmodule

// File: rtl/irpw_width_timer.sv
module irpw_width_timer
    import irpw_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      rx_en,
    input  logic      tick,
    input  edge_sel_e edges,
    input  logic      ir_in,
    output logic      push_o,
    output cap_word_t word_o,
    output logic      busy_o,
    output logic      tmo_evt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic       sync1_q, sync2_q, prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic       hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= ir_in;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    assign hit = edge_hit(edges, prev_q, sync2_q);

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            cnt_q     <= '0;
            busy_o    <= 1'b0;
            push_o    <= 1'b0;
            tmo_evt_o <= 1'b0;
            word_o    <= '0;
        end else begin
            push_o    <= 1'b0;
            tmo_evt_o <= 1'b0;
            if (hit) begin
                if (busy_o) begin
                    push_o       <= 1'b1;
                    word_o.level <= prev_q;
                    word_o.width <= WIDTH_FIELD_W'(cnt_q >> 2);
                end
                busy_o <= 1'b1;
                cnt_q  <= '0;
            end else if (tick && busy_o) begin
                if (cnt_q == CNT_MAX) begin
                    push_o    <= 1'b1;
                    word_o    <= end_marker();
                    busy_o    <= 1'b0;
                    tmo_evt_o <= 1'b1;
                    cnt_q     <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!busy_o && !push_o)); // R10

    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !hit) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/irpw_fifo.sv
module irpw_fifo
    import irpw_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en,
    input  logic                       push,
    input  cap_word_t                  din,
    input  logic                       pop,
    output cap_word_t                  dout,
    output logic [$clog2(DEPTH+1)-1:0] level_o,
    output logic                       ovr_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    cap_word_t        mem [DEPTH];
    logic [PTR_W-1:0] wp_q, rp_q;
    logic             full, do_pop, do_push;

    assign full    = (level_o == FULL_LVL);
    assign do_pop  = en && pop && (level_o != '0);
    assign do_push = en && push && (!full || do_pop);
    assign dout    = mem[rp_q];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp_q] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            wp_q    <= '0;
            rp_q    <= '0;
            level_o <= '0;
            ovr_o   <= 1'b0;
        end else begin
            if (do_push) begin
                wp_q <= (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
            end
            if (do_pop) begin
                rp_q <= (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   level_o <= level_o + 1'b1;
                2'b01:   level_o <= level_o - 1'b1;
                default: level_o <= level_o;
            endcase
            if (push && full && !do_pop) begin
                ovr_o <= 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        level_o <= FULL_LVL); // R6

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_o) |-> $past(push && full)); // R6

    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!ovr_o && level_o == '0)); // R8

endmodule

// File: rtl/irpw_rx_top.sv
module irpw_rx_top
    import irpw_pkg::*;
#(
    parameter int CNT_W = 18,
    parameter int DEPTH = 8,
    parameter int DIV_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ir_in,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    input  logic        reg_rd,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam logic [LVL_W-1:0] HALF_LVL = LVL_W'(DEPTH / 2);

    ctrl_t            ctrl_q;
    logic [DIV_W-1:0] div_q;
    flag_vec_t        irqen_q;
    flag_vec_t        flags;
    logic             tmo_q;

    logic             tick, push, busy, tmo_evt, pop, ovr;
    cap_word_t        cap_word, q_out;
    logic [LVL_W-1:0] q_level;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            div_q   <= '0;
            irqen_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                ADDR_CTRL:  ctrl_q  <= ctrl_t'(reg_wdata[4:0]);
                ADDR_DIV:   div_q   <= reg_wdata[DIV_W-1:0];
                ADDR_IRQEN: irqen_q <= flag_vec_t'(reg_wdata[2:0]);
                default:    ;
            endcase
        end
    end

    irpw_prescaler #(.DIV_W(DIV_W)) u_presc (
        .clk    (clk),
        .rst    (rst),
        .en     (ctrl_q.rx_en),
        .div_i  (div_q),
        .tick_o (tick)
    );

    irpw_width_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (ctrl_q.rx_en),
        .tick      (tick),
        .edges     (ctrl_q.edges),
        .ir_in     (ir_in),
        .push_o    (push),
        .word_o    (cap_word),
        .busy_o    (busy),
        .tmo_evt_o (tmo_evt)
    );

    assign pop = reg_rd && (reg_addr == ADDR_QUEUE);

    irpw_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .en      (ctrl_q.q_en),
        .push    (push),
        .din     (cap_word),
        .pop     (pop),
        .dout    (q_out),
        .level_o (q_level),
        .ovr_o   (ovr)
    );

    always_ff @(posedge clk) begin
        if (rst || !ctrl_q.rx_en) begin
            tmo_q <= 1'b0;
        end else if (tmo_evt) begin
            tmo_q <= 1'b1;
        end
    end

    assign flags.tmo = tmo_q;
    assign flags.ovr = ovr;
    assign flags.svc = ctrl_q.wm_any ? (q_level != '0) : (q_level >= HALF_LVL);
    assign irq       = |(flags & irqen_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_rd) begin
            case (reg_addr)
                ADDR_CTRL:  reg_rdata <= 32'(ctrl_q);
                ADDR_DIV:   reg_rdata <= 32'(div_q);
                ADDR_IRQEN: reg_rdata <= 32'(irqen_q);
                ADDR_STAT:  reg_rdata <= {28'd0, busy, flags.svc, flags.ovr, flags.tmo};
                ADDR_QUEUE: reg_rdata <= (q_level != '0) ? {14'd0, 1'b1, q_out} : 32'd0;
                default:    reg_rdata <= '0;
            endcase
        end
    end

    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (tmo_q && ctrl_q.rx_en) |=> tmo_q); // R9

    AST_TMO_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(tmo_q) |-> ($past(push) && $past(cap_word) == end_marker())); // R4

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (irqen_q == '0) |-> !irq); // R11

endmodule

// File: tb/irpw_rx_top_tb.sv
module irpw_rx_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ir_in = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    irpw_rx_top #(.CNT_W(12), .DEPTH(8), .DIV_W(16)) dut_i (
        .clk(clk), .rst(rst), .ir_in(ir_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [31:0] exp_word(input bit lvl, input int n);
        return 32'h20000 | (32'(lvl) << 16) | 32'((n - 1) >> 2);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart_rx(input logic [15:0] ctrl);
        wr(3'd0, 16'h0000);
        hold(2);
        wr(3'd0, ctrl);
    endtask

    task automatic pulse_n(input int count, input int gap);
        for (int i = 0; i < count; i++) begin
            ir_in = ~ir_in;
            hold(gap);
        end
    endtask

    initial begin
        logic [31:0] v;
        int w [3];
        hold(3);
        rst = 1'b0;
        hold(1);

        // reset state
        rd(3'd3, v); check(v == 0, "R10 reset status", v, 0);
        check(irq == 0, "R11 reset irq", 32'(irq), 0);
        rd(3'd4, v); check(v == 0, "R3 empty read after reset", v, 0);

        // random trains, divider 0, both edges, wm any
        wr(3'd1, 16'd0);
        wr(3'd0, 16'h001F);
        for (int r = 0; r < 6; r++) begin
            for (int k = 0; k < 3; k++) w[k] = 8 + int'($urandom % 150);
            ir_in = 1'b1; hold(w[0]);
            ir_in = 1'b0; hold(w[1]);
            ir_in = 1'b1; hold(w[2]);
            ir_in = 1'b0; hold(6);
            rd(3'd3, v); check(v[3] == 1'b1, "R10 busy while timing", v, 32'h8);
            rd(3'd4, v); check(v == exp_word(1, w[0]), "R2 R3 word high", v, exp_word(1, w[0]));
            rd(3'd4, v); check(v == exp_word(0, w[1]), "R2 R3 word low", v, exp_word(0, w[1]));
            rd(3'd4, v); check(v == exp_word(1, w[2]), "R2 R3 word high 2", v, exp_word(1, w[2]));
            rd(3'd4, v); check(v == 0, "R3 empty read", v, 0);
            restart_rx(16'h001F);
        end

        // divider 3: width about n/16
        wr(3'd1, 16'd3);
        restart_rx(16'h001F);
        ir_in = 1'b1; hold(160);
        ir_in = 1'b0; hold(8);
        rd(3'd4, v);
        check(v[17] && (v[15:0] >= 16'd9) && (v[15:0] <= 16'd11), "R1 divider 3 width", v, 32'h3000A);
        wr(3'd1, 16'd0);
        restart_rx(16'h001F);

        // falling only
        restart_rx(16'h0017);
        ir_in = 1'b1; hold(20);
        ir_in = 1'b0; hold(40);
        ir_in = 1'b1; hold(60);
        ir_in = 1'b0; hold(6);
        rd(3'd4, v); check(v == exp_word(1, 100), "R5 falling only", v, exp_word(1, 100));
        rd(3'd4, v); check(v == 0, "R5 falling only single word", v, 0);

        // rising only
        restart_rx(16'h001B);
        ir_in = 1'b1; hold(40);
        ir_in = 1'b0; hold(60);
        ir_in = 1'b1; hold(20);
        ir_in = 1'b0; hold(6);
        rd(3'd4, v); check(v == exp_word(0, 100), "R5 rising only", v, exp_word(0, 100));
        rd(3'd4, v); check(v == 0, "R5 rising ignores fall", v, 0);

        // none
        restart_rx(16'h0013);
        pulse_n(4, 12);
        rd(3'd3, v); check(v[3] == 1'b0, "R5 none not busy", v, 0);
        rd(3'd4, v); check(v == 0, "R5 none queues nothing", v, 0);

        // overrun
        restart_rx(16'h001F);
        pulse_n(10, 12);
        hold(4);
        rd(3'd3, v); check(v[1] == 1'b1, "R6 overrun set", v, 32'h2);
        for (int i = 0; i < 8; i++) begin
            rd(3'd4, v); check(v == exp_word(i % 2 == 0, 12), "R6 stored word", v, exp_word(i % 2 == 0, 12));
        end
        rd(3'd4, v); check(v == 0, "R6 ninth word dropped", v, 0);
        rd(3'd3, v); check(v[1] == 1'b1, "R8 overrun survives reads", v, 32'h2);
        wr(3'd0, 16'h001D); hold(1);
        wr(3'd0, 16'h001F);
        rd(3'd3, v); check(v[1] == 1'b0, "R8 overrun cleared by queue enable cycle", v, 0);

        // watermark half
        restart_rx(16'h000F);
        pulse_n(4, 12);
        rd(3'd3, v); check(v[2] == 1'b0, "R7 three words below half", v, 0);
        wr(3'd2, 16'h0004);
        check(irq == 0, "R11 irq low without service", 32'(irq), 0);
        pulse_n(1, 8);
        rd(3'd3, v); check(v[2] == 1'b1, "R7 four words at half", v, 32'h4);
        check(irq == 1, "R11 service irq", 32'(irq), 1);
        wr(3'd2, 16'h0003); hold(1);
        check(irq == 0, "R11 service irq masked", 32'(irq), 0);
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'h0000);
        ir_in = 1'b0; hold(4);

        // watermark any
        wr(3'd0, 16'h001F);
        pulse_n(2, 12);
        rd(3'd3, v); check(v[2] == 1'b1, "R7 one word not empty", v, 32'h4);

        // receiver disable stops capture
        restart_rx(16'h001F);
        ir_in = 1'b1; hold(10);
        rd(3'd3, v); check(v[3] == 1'b1, "R10 busy after start", v, 32'h8);
        wr(3'd0, 16'h001E); hold(2);
        rd(3'd3, v); check(v[3] == 1'b0, "R10 disable clears busy", v, 0);
        pulse_n(5, 10);
        rd(3'd4, v); check(v == 0, "R10 no words while disabled", v, 0);
        wr(3'd0, 16'h001E); hold(1);
        ir_in = 1'b0; hold(4);

        // timeout
        wr(3'd2, 16'h0001);
        restart_rx(16'h001F);
        ir_in = 1'b1; hold(4200);
        rd(3'd3, v); check(v[0] == 1'b1 && v[3] == 1'b0, "R4 timeout flag", v, 32'h1);
        check(irq == 1, "R11 timeout irq", 32'(irq), 1);
        rd(3'd4, v); check(v == 32'h3FFFF, "R4 end marker", v, 32'h3FFFF);
        hold(20);
        rd(3'd3, v); check(v[0] == 1'b1, "R9 timeout sticky", v, 32'h1);
        wr(3'd0, 16'h001E); hold(1);
        wr(3'd0, 16'h001F);
        rd(3'd3, v); check(v[0] == 1'b0, "R9 timeout cleared by enable cycle", v, 0);
        check(irq == 0, "R11 irq drops", 32'(irq), 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog got=%h exp=%h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule